// File: doc/BRIEF.md
# PLCP Receive Alarm and Error Monitor

This block sits behind a PLCP receive framer and turns its per-frame observations into status bits and error counters. Once per received PLCP frame the framer presents one transfer. The transfer carries flags for errors in the two framing octets, the current loss-of-frame state, the received yellow-alarm bit, a BIP-8 mismatch flag and the 4-bit far-end block error (FEBE) nibble. A separate one-second tick input times how long loss-of-frame lasts.

The frame interface is valid/ready. `frm_ready` is always high, so the monitor never applies back-pressure. A frame is consumed on every clock edge where `frm_valid` is high, and the fields are ignored when `frm_valid` is low. Error status bits are sticky. They and the three saturating counters are cleared by the one-cycle `clr_rd` strobe that software issues when it reads them. The yellow and long-loss indications are levels and are not affected by the strobe.

Top module: `plcp_rx_monitor`

## Requirements
- R1: An accepted frame with `frm_a1_err` or `frm_a2_err` high sets `sts_frame_err` and adds exactly one to `cnt_frm_err`, even when both flags are high.
- R2: An accepted frame with `frm_bip_err` high sets `sts_bip_err` and adds one to `cnt_bip_err`.
- R3: An accepted frame with a FEBE nibble from 1 to 8 sets `sts_febe_err` and adds the nibble value to `cnt_rei`. A nibble of 0 changes nothing.
- R4: A FEBE nibble from 9 to 15 sets `sts_febe_inv` and leaves `cnt_rei` unchanged. The value 15 also sets `sts_febe_ones`.
- R5: `sts_yellow` rises after YEL_FRAMES (default 10) consecutive accepted frames with the yellow bit at 1. It falls after YEL_FRAMES consecutive accepted frames with the bit at 0. A frame that agrees with the current status restarts the run.
- R6: `sts_lof_long` rises one cycle after the LOF_EDGES-th (default 3) consecutive rising edge of `sec_tick` at which the loss-of-frame state from the last accepted frame is 1.
- R7: At a `sec_tick` rising edge where that loss-of-frame state is 0, the edge count returns to zero and `sts_lof_long` falls.
- R8: A `sec_tick` held high for several cycles counts as one edge.
- R9: Every counter saturates at 2^CNT_W-1 (255 by default) and never wraps.
- R10: `clr_rd` zeroes the sticky error bits and all counters. An event in the same cycle wins: its bit stays set and its counter holds only that event's increment.
- R11: Fields presented with `frm_valid` low change no output, and `frm_ready` is always 1.
- R12: After reset all status outputs and counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid | input | 1 | Frame observation present |
| frm_ready | output | 1 | Always high, no back-pressure |
| frm_a1_err | input | 1 | First framing octet in error |
| frm_a2_err | input | 1 | Second framing octet in error |
| frm_lof | input | 1 | Framer in loss-of-frame |
| frm_yellow | input | 1 | Received yellow-alarm bit |
| frm_bip_err | input | 1 | BIP-8 mismatch for this frame |
| frm_febe | input | 4 | Far-end block error nibble |
| sec_tick | input | 1 | One-second tick |
| clr_rd | input | 1 | Clear-on-read strobe |
| sts_frame_err | output | 1 | Sticky framing-octet error |
| sts_yellow | output | 1 | Integrated yellow alarm |
| sts_lof_long | output | 1 | Long-duration loss-of-frame |
| sts_bip_err | output | 1 | Sticky BIP-8 error |
| sts_febe_err | output | 1 | Sticky valid non-zero FEBE |
| sts_febe_inv | output | 1 | Sticky invalid FEBE |
| sts_febe_ones | output | 1 | Sticky FEBE all ones |
| cnt_frm_err | output | CNT_W | Framing error count |
| cnt_bip_err | output | CNT_W | BIP-8 error count |
| cnt_rei | output | CNT_W | Remote block error sum |

## Verification
The hardest states to reach are the run-length corners: the yellow integrator at exactly nine agreeing frames, and the one-second counter after a loss-of-frame gap inside an otherwise long outage. The stimulus builds these with directed frame runs that stop one short of the threshold, break the run with a single opposite frame, and then rebuild it. The tick is driven only when no frame is in flight, and one tick is held high for several cycles. Saturation is reached by streaming a few hundred error frames so the remote count crosses 255 in steps of eight.

// File: rtl/plcp_mon_pkg.sv
package plcp_mon_pkg;
  typedef enum logic [1:0] {
    FEBE_NONE,
    FEBE_GOOD,
    FEBE_BAD,
    FEBE_ONES
  } febe_class_e;

  function automatic febe_class_e classify_febe(input logic [3:0] v);
    if (v == 4'd0)       return FEBE_NONE;
    else if (v <= 4'd8)  return FEBE_GOOD;
    else if (v == 4'hF)  return FEBE_ONES;
    else                 return FEBE_BAD;
  endfunction
endpackage

// File: rtl/plcp_sat_counter.sv
module plcp_sat_counter #(
  parameter int W     = 8,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = clr ? '0 : cnt;
    sum  = {1'b0, base} + (W+1)'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (sum[W]) cnt <= MAXV;
    else             cnt <= sum[W-1:0];
  end
endmodule

// File: rtl/plcp_yellow_integ.sv
module plcp_yellow_integ #(
  parameter int N = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic bit_in,
  output logic alarm
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      alarm <= 1'b0;
    end else if (frame) begin
      if (bit_in == alarm) begin
        run <= '0;
      end else if (run == CW'(N - 1)) begin
        run   <= '0;
        alarm <= bit_in;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/plcp_lof_timer.sv
module plcp_lof_timer #(
  parameter int EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  input  logic lof_in,
  input  logic tick,
  output logic long_lof
);
  localparam int CW = $clog2(EDGES + 1);
  logic          tick_q;
  logic          lof_q;
  logic          edge_seen;
  logic [CW-1:0] edges;

  assign edge_seen = tick && !tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= 1'b0;
      lof_q    <= 1'b0;
      edges    <= '0;
      long_lof <= 1'b0;
    end else begin
      tick_q <= tick;
      if (frame) lof_q <= lof_in;
      if (edge_seen) begin
        if (!lof_q) begin
          edges    <= '0;
          long_lof <= 1'b0;
        end else if (edges == CW'(EDGES - 1)) begin
          edges    <= edges + 1'b1;
          long_lof <= 1'b1;
        end else if (edges < CW'(EDGES - 1)) begin
          edges <= edges + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/plcp_rx_monitor.sv
module plcp_rx_monitor
  import plcp_mon_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int YEL_FRAMES = 10,
  parameter int LOF_EDGES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic             frm_a1_err,
  input  logic             frm_a2_err,
  input  logic             frm_lof,
  input  logic             frm_yellow,
  input  logic             frm_bip_err,
  input  logic [3:0]       frm_febe,
  input  logic             sec_tick,
  input  logic             clr_rd,
  output logic             sts_frame_err,
  output logic             sts_yellow,
  output logic             sts_lof_long,
  output logic             sts_bip_err,
  output logic             sts_febe_err,
  output logic             sts_febe_inv,
  output logic             sts_febe_ones,
  output logic [CNT_W-1:0] cnt_frm_err,
  output logic [CNT_W-1:0] cnt_bip_err,
  output logic [CNT_W-1:0] cnt_rei
);
  localparam int NSTK = 5;

  febe_class_e     fclass;
  logic            take;
  logic            ev_frame, ev_bip, ev_good, ev_inv, ev_ones;
  logic [3:0]      rei_inc;
  logic [NSTK-1:0] ev_vec, stk_q;

  assign frm_ready = 1'b1;
  assign take      = frm_valid && frm_ready;
  assign fclass    = classify_febe(frm_febe);

  always_comb begin
    ev_frame = take && (frm_a1_err || frm_a2_err);
    ev_bip   = take && frm_bip_err;
    ev_good  = take && (fclass == FEBE_GOOD);
    ev_ones  = take && (fclass == FEBE_ONES);
    ev_inv   = take && (fclass == FEBE_BAD || fclass == FEBE_ONES);
    rei_inc  = ev_good ? frm_febe : 4'd0;
  end

  assign ev_vec = {ev_ones, ev_inv, ev_good, ev_bip, ev_frame};

  for (genvar g = 0; g < NSTK; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stk_q[g] <= 1'b0;
      else if (ev_vec[g]) stk_q[g] <= 1'b1;
      else if (clr_rd)    stk_q[g] <= 1'b0;
    end
  end

  assign sts_frame_err = stk_q[0];
  assign sts_bip_err   = stk_q[1];
  assign sts_febe_err  = stk_q[2];
  assign sts_febe_inv  = stk_q[3];
  assign sts_febe_ones = stk_q[4];

  plcp_sat_counter #(.W(CNT_W), .INC_W(1)) i_cnt_frm (
    .clk(clk), .rst_n(rst_n), .clr(clr_rd), .inc(ev_frame), .cnt(cnt_frm_err));

  plcp_sat_counter #(.W(CNT_W), .INC_W(1)) i_cnt_bip (
    .clk(clk), .rst_n(rst_n), .clr(clr_rd), .inc(ev_bip), .cnt(cnt_bip_err));

  plcp_sat_counter #(.W(CNT_W), .INC_W(4)) i_cnt_rei (
    .clk(clk), .rst_n(rst_n), .clr(clr_rd), .inc(rei_inc), .cnt(cnt_rei));

  plcp_yellow_integ #(.N(YEL_FRAMES)) i_yellow (
    .clk(clk), .rst_n(rst_n), .frame(take), .bit_in(frm_yellow), .alarm(sts_yellow));

  plcp_lof_timer #(.EDGES(LOF_EDGES)) i_lof (
    .clk(clk), .rst_n(rst_n), .frame(take), .lof_in(frm_lof),
    .tick(sec_tick), .long_lof(sts_lof_long));
endmodule

// File: rtl/plcp_mon_chk.sv
module plcp_mon_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             frm_a1_err,
  input logic             frm_a2_err,
  input logic             frm_bip_err,
  input logic [3:0]       frm_febe,
  input logic             sec_tick,
  input logic             clr_rd,
  input logic             sts_frame_err,
  input logic             sts_yellow,
  input logic             sts_lof_long,
  input logic             sts_bip_err,
  input logic             sts_febe_inv,
  input logic             sts_febe_ones,
  input logic [CNT_W-1:0] cnt_frm_err,
  input logic [CNT_W-1:0] cnt_rei
);
  AST_FRAME_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && (frm_a1_err || frm_a2_err) |=> sts_frame_err); // R1
  AST_BIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_bip_err |=> sts_bip_err); // R2
  AST_FEBE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_febe == 4'hF |=> sts_febe_ones && sts_febe_inv); // R4
  AST_YELLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(sts_yellow)); // R5
  AST_LOF_LONG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_lof_long) |-> $past(sec_tick) && !$past(sec_tick, 2)); // R6
  AST_NO_WRAP_FRM: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd |=> cnt_frm_err >= $past(cnt_frm_err)); // R9
  AST_NO_WRAP_REI: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd |=> cnt_rei >= $past(cnt_rei)); // R9
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid && !clr_rd |=> $stable(cnt_frm_err) && $stable(cnt_rei)); // R11
endmodule

bind plcp_rx_monitor plcp_mon_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_a1_err(frm_a1_err),
  .frm_a2_err(frm_a2_err), .frm_bip_err(frm_bip_err), .frm_febe(frm_febe),
  .sec_tick(sec_tick), .clr_rd(clr_rd), .sts_frame_err(sts_frame_err),
  .sts_yellow(sts_yellow), .sts_lof_long(sts_lof_long), .sts_bip_err(sts_bip_err),
  .sts_febe_inv(sts_febe_inv), .sts_febe_ones(sts_febe_ones),
  .cnt_frm_err(cnt_frm_err), .cnt_rei(cnt_rei));

// File: tb/test_plcp_rx_monitor.sv
`timescale 1ns/1ps
module test_plcp_rx_monitor;
  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, frm_a1_err = 0, frm_a2_err = 0, frm_lof = 0;
  logic frm_yellow = 0, frm_bip_err = 0, sec_tick = 0, clr_rd = 0;
  logic [3:0] frm_febe = 0;
  logic frm_ready, sts_frame_err, sts_yellow, sts_lof_long, sts_bip_err;
  logic sts_febe_err, sts_febe_inv, sts_febe_ones;
  logic [7:0] cnt_frm_err, cnt_bip_err, cnt_rei;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  plcp_rx_monitor i_plcp_rx_monitor (.*);

  // fields: a1, a2, bip, febe[3:0], exp frm cnt, exp bip cnt, exp rei cnt,
  // exp flags {frame_err, bip_err, febe_err, febe_inv, febe_ones}
  localparam logic [35:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b0, 4'd0,  8'd1, 8'd0, 8'd0,  5'b10000},
    {1'b0, 1'b1, 1'b1, 4'd3,  8'd2, 8'd1, 8'd3,  5'b11100},
    {1'b1, 1'b1, 1'b0, 4'd8,  8'd3, 8'd1, 8'd11, 5'b11100},
    {1'b0, 1'b0, 1'b0, 4'd9,  8'd3, 8'd1, 8'd11, 5'b11110},
    {1'b0, 1'b0, 1'b0, 4'd15, 8'd3, 8'd1, 8'd11, 5'b11111},
    {1'b0, 1'b0, 1'b0, 4'd0,  8'd3, 8'd1, 8'd11, 5'b11111}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(input logic a1, a2, bip, lof, yel, input logic [3:0] febe);
    @(negedge clk);
    frm_valid = 1; frm_a1_err = a1; frm_a2_err = a2; frm_bip_err = bip;
    frm_lof = lof; frm_yellow = yel; frm_febe = febe;
    @(negedge clk);
    frm_valid = 0; frm_a1_err = 0; frm_a2_err = 0; frm_bip_err = 0; frm_febe = 0;
  endtask

  task automatic tick(input int hold);
    @(negedge clk); sec_tick = 1;
    repeat (hold) @(negedge clk);
    sec_tick = 0;
    @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); clr_rd = 1;
    @(negedge clk); clr_rd = 0;
  endtask

  function automatic int flags();
    return {sts_frame_err, sts_bip_err, sts_febe_err, sts_febe_inv, sts_febe_ones};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 flags", flags(), 0);
    check("R12 counts", cnt_frm_err + cnt_bip_err + cnt_rei, 0);
    check("R12 levels", {sts_yellow, sts_lof_long}, 0);
    rst_n = 1;
    check("R11 ready", frm_ready, 1);

    for (int i = 0; i < 6; i++) begin
      frame(VEC[i][35], VEC[i][34], VEC[i][33], 0, 0, VEC[i][32:29]);
      check("R1 frame count", cnt_frm_err, VEC[i][28:21]);
      check("R2 bip count", cnt_bip_err, VEC[i][20:13]);
      check("R3 rei sum", cnt_rei, VEC[i][12:5]);
      check("R4 flags", flags(), VEC[i][4:0]);
    end

    clear();
    check("R10 cleared flags", flags(), 0);
    check("R10 cleared counts", cnt_frm_err + cnt_bip_err + cnt_rei, 0);

    // R11: fields with valid low are ignored
    @(negedge clk);
    frm_a1_err = 1; frm_bip_err = 1; frm_febe = 4'd15; frm_yellow = 1;
    @(negedge clk);
    frm_a1_err = 0; frm_bip_err = 0; frm_febe = 0; frm_yellow = 0;
    check("R11 idle flags", flags(), 0);
    check("R11 idle counts", cnt_frm_err + cnt_bip_err + cnt_rei, 0);

    // R10: event in same cycle as clear wins
    frame(1, 0, 0, 0, 0, 4'd5);
    @(negedge clk);
    clr_rd = 1; frm_valid = 1; frm_a2_err = 1;
    @(negedge clk);
    clr_rd = 0; frm_valid = 0; frm_a2_err = 0;
    check("R10 clear+event count", cnt_frm_err, 1);
    check("R10 clear+event flag", sts_frame_err, 1);
    check("R10 rei cleared", cnt_rei, 0);

    // R9 saturation
    clear();
    for (int i = 0; i < 300; i++) frame(1, 0, 1, 0, 0, 4'd8);
    check("R9 frame sat", cnt_frm_err, 255);
    check("R9 bip sat", cnt_bip_err, 255);
    check("R9 rei sat", cnt_rei, 255);

    // R5 yellow hysteresis
    for (int i = 0; i < 9; i++) frame(0, 0, 0, 0, 1, 0);
    check("R5 nine ones", sts_yellow, 0);
    frame(0, 0, 0, 0, 1, 0);
    check("R5 ten ones", sts_yellow, 1);
    for (int i = 0; i < 5; i++) frame(0, 0, 0, 0, 0, 0);
    frame(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 9; i++) frame(0, 0, 0, 0, 0, 0);
    check("R5 broken run holds", sts_yellow, 1);
    frame(0, 0, 0, 0, 0, 0);
    check("R5 ten zeros", sts_yellow, 0);

    // R6, R8 long loss-of-frame
    frame(0, 0, 0, 1, 0, 0);
    tick(1);
    tick(5);
    check("R8 long tick once", sts_lof_long, 0);
    tick(1);
    check("R6 third edge", sts_lof_long, 1);
    frame(0, 0, 0, 0, 0, 0);
    tick(1);
    check("R7 lof low clears", sts_lof_long, 0);

    // R7 gap resets the edge count
    frame(0, 0, 0, 1, 0, 0);
    tick(1); tick(1);
    frame(0, 0, 0, 0, 0, 0);
    tick(1);
    frame(0, 0, 0, 1, 0, 0);
    tick(1); tick(1);
    check("R7 count restarted", sts_lof_long, 0);
    tick(1);
    check("R6 after restart", sts_lof_long, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule